// File: doc/BRIEF.md
# Interrupt Entry Arbiter with Vector Select

This block sits beside the status register and the fetch sequencer of a small 8-bit processor core. When an instruction finishes, it decides whether the core moves into an interrupt entry instead of fetching the next opcode. It then supplies the handler address and the value of the break bit that goes into the status byte pushed on the stack. It also gives a one-cycle pulse that tells the status register to set its interrupt-disable flag.

Three sources compete for service. A non-maskable request is detected on the falling edge of its active-low line and is held until it is serviced. A maskable request is a level on its own active-low line and counts only while the interrupt-disable flag is clear. A software break request comes from the decoder. Requests are looked at only on the instruction-boundary strobe. A software break is the lowest-priority source, and it opens a short window after it is accepted. If a non-maskable edge arrives inside that window, the entry is moved to the non-maskable vector, but the pushed break bit stays set. This lets the handler see that a break was in progress.

Top module: `irqv_entry`

## Requirements
- R1: Synchronous reset, active high, leaves `take_o`=0, `vector_o`=16'hFFFE and `push_b_o`=1. A non-maskable line that is already low while reset is held does not count as an edge after reset is released.
- R2: On a boundary cycle with no non-maskable request pending, `irq_n_i`=0 and `i_flag_i`=0, the next cycle shows `take_o`=1, `vector_o`=16'hFFFE and `push_b_o`=0.
- R3: When `i_flag_i`=1, a low `irq_n_i` causes no entry. A break request made in the same cycle is then still serviced.
- R4: A high-to-low transition of `nmi_n_i` is held until a boundary cycle services it with `vector_o`=16'hFFFA and `push_b_o`=0. Keeping the line low afterwards gives no further entry.
- R5: On a boundary cycle, a pending non-maskable request wins over both the maskable request and a break request.
- R6: A break request (`brk_req_i`=1) on a boundary cycle with no hardware request being serviced gives `take_o`=1, `vector_o`=16'hFFFE and `push_b_o`=1. A serviced maskable request wins over the break.
- R7: A non-maskable edge sampled in any of the HIJACK_CYCLES (default 4) clock edges after a break entry moves `vector_o` to 16'hFFFA and keeps `push_b_o`=1. It gives no second `take_o` pulse and it uses up the request.
- R8: A non-maskable edge sampled after that window has closed leaves the break vector unchanged. It stays pending and is serviced normally at the next boundary.
- R9: `take_o` is a single-cycle pulse one clock after an accepted boundary cycle. It never appears without the strobe. Boundary strobes are ignored while `take_o` is high or a break window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n_i | input | 1 | Maskable request, level, active low |
| nmi_n_i | input | 1 | Non-maskable request, falling-edge sensitive |
| brk_req_i | input | 1 | Software break request from the decoder |
| i_flag_i | input | 1 | Current interrupt-disable flag |
| boundary_i | input | 1 | Instruction-boundary strobe |
| vector_o | output | VEC_W | Handler vector address |
| push_b_o | output | 1 | Break bit for the pushed status byte |
| take_o | output | 1 | Entry pulse; the status register sets its disable flag on it |

## Verification
Several properties are checked on every cycle. Every entry must follow a boundary strobe and last a single cycle. A non-maskable entry must push the break bit clear, and a masked level must never be serviced. A latched edge must persist until it is cleared. A vector change outside an entry pulse is allowed only as the break hijack, with the break bit still set. The bench scenarios are needed to show the rest. These are the full priority order over every mix of requests, where the window's edges fall, and that a hijacked request is used up while a late one survives. They also cover the cases that are ignored: a masked level, a held-low line, and strobes during an entry.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Source chosen for service on a boundary cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_BRK  = 2'd3
  } src_e;

endpackage

// File: rtl/irqv_nmi_latch.sv
module irqv_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n_i,
  input  logic clear_i,
  output logic pend_now_o
);

  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall       = prev_q & ~nmi_n_i;
  assign pend_now_o = pend_q | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= nmi_n_i;  // follow the line so a low level at release is no edge
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n_i;
      if (clear_i)   pend_q <= 1'b0;
      else if (fall) pend_q <= 1'b1;
    end
  end

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clear_i) |=> pend_q); // R4
  AST_NMI_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (prev_q && !nmi_n_i && !clear_i) |=> pend_q); // R4

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic eval_i,
  input  logic nmi_pend_i,
  input  logic irq_n_i,
  input  logic i_flag_i,
  input  logic brk_req_i,
  output src_e sel_o
);

  always_comb begin
    sel_o = SRC_NONE;
    if (eval_i) begin
      if (nmi_pend_i)                sel_o = SRC_NMI;
      else if (!irq_n_i && !i_flag_i) sel_o = SRC_IRQ;
      else if (brk_req_i)            sel_o = SRC_BRK;
    end
  end

endmodule

// File: rtl/irqv_hijack_win.sv
module irqv_hijack_win #(
  parameter int unsigned WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic nmi_pend_i,
  output logic active_o,
  output logic hijack_o
);

  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt_q;

  assign active_o = (cnt_q != '0);
  assign hijack_o = active_o & nmi_pend_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(WIN);
    end else if (active_o) begin
      if (nmi_pend_i) cnt_q <= '0;
      else            cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WIN)); // R7
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (hijack_o && !start_i) |=> !active_o); // R7

endmodule

// File: rtl/irqv_entry.sv
module irqv_entry
  import irqv_pkg::*;
#(
  parameter int unsigned VEC_W        = 16,
  parameter logic [15:0] NMI_VEC      = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC      = 16'hFFFE,
  parameter int unsigned HIJACK_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_n_i,
  input  logic             nmi_n_i,
  input  logic             brk_req_i,
  input  logic             i_flag_i,
  input  logic             boundary_i,
  output logic [VEC_W-1:0] vector_o,
  output logic             push_b_o,
  output logic             take_o
);

  localparam logic [VEC_W-1:0] V_NMI = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] V_IRQ = VEC_W'(IRQ_VEC);

  logic nmi_pend;
  logic win_active;
  logic hijack;
  logic eval;
  logic nmi_clear;
  src_e sel;

  assign eval      = boundary_i & ~take_o & ~win_active;
  assign nmi_clear = (sel == SRC_NMI) | hijack;

  irqv_nmi_latch u_nmi (
    .clk        (clk),
    .rst        (rst),
    .nmi_n_i    (nmi_n_i),
    .clear_i    (nmi_clear),
    .pend_now_o (nmi_pend)
  );

  irqv_arbiter u_arb (
    .eval_i     (eval),
    .nmi_pend_i (nmi_pend),
    .irq_n_i    (irq_n_i),
    .i_flag_i   (i_flag_i),
    .brk_req_i  (brk_req_i),
    .sel_o      (sel)
  );

  irqv_hijack_win #(.WIN(HIJACK_CYCLES)) u_win (
    .clk        (clk),
    .rst        (rst),
    .start_i    (sel == SRC_BRK),
    .nmi_pend_i (nmi_pend),
    .active_o   (win_active),
    .hijack_o   (hijack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o   <= 1'b0;
      vector_o <= V_IRQ;
      push_b_o <= 1'b1;
    end else begin
      take_o <= (sel != SRC_NONE);
      unique case (sel)
        SRC_NMI: begin vector_o <= V_NMI; push_b_o <= 1'b0; end
        SRC_IRQ: begin vector_o <= V_IRQ; push_b_o <= 1'b0; end
        SRC_BRK: begin vector_o <= V_IRQ; push_b_o <= 1'b1; end
        default: if (hijack) vector_o <= V_NMI;  // break bit is kept
      endcase
    end
  end

  AST_TAKE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i)); // R9
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o); // R9
  AST_NMI_B_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (take_o && vector_o == V_NMI) |-> !push_b_o); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (take_o && !push_b_o && vector_o == V_IRQ) |-> !$past(i_flag_i)); // R3
  AST_HIJACK_KEEPS_B: assert property (@(posedge clk) disable iff (rst)
    (!take_o && !$stable(vector_o)) |-> (push_b_o && vector_o == V_NMI)); // R7

endmodule

// File: tb/irqv_entry_tb.sv
module irqv_entry_tb;

  localparam int unsigned WIN = 4;
  localparam logic [15:0] NV  = 16'hFFFA;
  localparam logic [15:0] IV  = 16'hFFFE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_n = 1'b1, nmi_n = 1'b1, brk_req = 1'b0, i_flag = 1'b0, boundary = 1'b0;
  logic [15:0] vector;
  logic push_b, take;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irqv_entry #(.HIJACK_CYCLES(WIN)) u_dut (
    .clk(clk), .rst(rst), .irq_n_i(irq_n), .nmi_n_i(nmi_n), .brk_req_i(brk_req),
    .i_flag_i(i_flag), .boundary_i(boundary), .vector_o(vector),
    .push_b_o(push_b), .take_o(take)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // take, vector, break bit packed as {take, vector, b}
  function automatic logic [17:0] obs();
    return {take, vector, push_b};
  endfunction

  task automatic expect_entry(input string tag, input logic [15:0] v, input logic b);
    chk(obs() == {1'b1, v, b}, tag, 32'(obs()), 32'({1'b1, v, b}));
  endtask

  task automatic expect_none(input string tag);
    chk(take == 1'b0, tag, 32'(take), 32'd0);
  endtask

  task automatic pulse_boundary();
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset with the non-maskable line already low
    nmi_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(obs() == {1'b0, IV, 1'b1}, "R1 reset state", 32'(obs()), 32'({1'b0, IV, 1'b1}));
    pulse_boundary();
    expect_none("R1 low line at reset is no edge");
    nmi_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep all request mixes on a boundary: irq, i flag, break, nmi edge
    for (int m = 0; m < 16; m++) begin
      bit rq, fl, bk, nf;
      string tag;
      {rq, fl, bk, nf} = 4'(m);
      @(negedge clk);
      irq_n = !rq; i_flag = fl; brk_req = bk; boundary = 1'b1; nmi_n = !nf;
      @(negedge clk);
      boundary = 1'b0; brk_req = 1'b0; irq_n = 1'b1;
      if (nf) begin
        tag = (rq || bk) ? "R5 nmi outranks others" : "R4 nmi edge serviced";
        expect_entry(tag, NV, 1'b0);
      end else if (rq && !fl) begin
        tag = bk ? "R6 irq outranks break" : "R2 irq serviced";
        expect_entry(tag, IV, 1'b0);
      end else if (bk) begin
        tag = rq ? "R3 masked irq lets break through" : "R6 break entry";
        expect_entry(tag, IV, 1'b1);
      end else begin
        tag = rq ? "R3 masked irq ignored" : "R9 idle boundary";
        expect_none(tag);
      end
      nmi_n = 1'b1; i_flag = 1'b0;
      repeat (WIN + 3) @(negedge clk);
    end

    // R9: no entry without a strobe, even with an unmasked level
    irq_n = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      expect_none("R9 no strobe no entry");
    end
    pulse_boundary();
    expect_entry("R9 strobe gives entry", IV, 1'b0);
    @(negedge clk);
    expect_none("R9 entry is one cycle");
    irq_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4: held-low line serviced once
    @(negedge clk); nmi_n = 1'b0; boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    expect_entry("R4 held nmi first entry", NV, 1'b0);
    repeat (3) @(negedge clk);
    pulse_boundary();
    expect_none("R4 held nmi no retrigger");
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: strobes during a break window are ignored
    @(negedge clk); brk_req = 1'b1; boundary = 1'b1;
    @(negedge clk); brk_req = 1'b0; irq_n = 1'b0;
    expect_entry("R6 break before window", IV, 1'b1);
    @(negedge clk); boundary = 1'b0;
    expect_none("R9 strobe in window ignored");
    repeat (WIN + 1) @(negedge clk);
    pulse_boundary();
    expect_entry("R9 irq after window", IV, 1'b0);
    irq_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 / R8: NMI edge at every offset across the window and past it
    for (int d = 1; d <= int'(WIN) + 2; d++) begin
      @(negedge clk); brk_req = 1'b1; boundary = 1'b1;
      @(negedge clk); brk_req = 1'b0; boundary = 1'b0;
      expect_entry("R6 break start", IV, 1'b1);
      if (d > 1) repeat (d - 1) @(negedge clk);
      nmi_n = 1'b0;
      @(negedge clk);
      if (d <= int'(WIN))
        chk(obs() == {1'b0, NV, 1'b1}, "R7 hijack redirects vector", 32'(obs()), 32'({1'b0, NV, 1'b1}));
      else
        chk(obs() == {1'b0, IV, 1'b1}, "R8 late edge leaves vector", 32'(obs()), 32'({1'b0, IV, 1'b1}));
      repeat (WIN + 2) @(negedge clk);
      pulse_boundary();
      if (d <= int'(WIN)) expect_none("R7 hijacked request consumed");
      else                expect_entry("R8 late edge serviced later", NV, 1'b0);
      nmi_n = 1'b1;
      repeat (3) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule